// File: doc/BRIEF.md
# Request/Grant Bus Ownership Controller

This block sits on the bus-master side of a processor and decides when the processor lends its bus to an outside device. A static configuration input selects one of two schemes. In level mode a single device raises a hold level and receives an acknowledge level while it owns the bus. In pulse mode each of the coprocessor channels has one shared wire. Ownership of the bus passes through three single-clock pulses on that wire. The coprocessor sends a pulse to request the bus. The controller sends a pulse to grant it. The coprocessor sends a further pulse to return it. The shared wire is modelled as a sampled input `rg_in` and a per-channel drive output `rg_drv`. While `rg_drv` is high, the controller is driving the grant pulse.

A gating input selects how pulse-mode requests are served. With `serve_always` high they are served at any time. With `serve_always` low they are served only while `cpu_run` is high. A request that arrives while service is gated off is latched as pending and is served once `cpu_run` rises. After a request is detected, the controller floats the bus for one cycle before it drives the grant pulse. The grant therefore always comes at least one clock after the request. The controller reports the bus-float enable, whether a latched request is waiting, and a code naming the current owner.

Top module: `rgc_bus_owner_ctl`

## Requirements
- R1: While reset is active and after it is released with no requests, `bus_owner` is 0 (processor), and `bus_float`, `hold_ack`, `req_pending` and every `rg_drv` bit are 0.
- R2: In pulse mode, a one-cycle pulse on `rg_in[i]` is sampled at a clock edge, and `req_pending` is 1 after that edge. Only when service is allowed: one edge later `bus_float` rises while `bus_owner` is still 0, and `req_pending` drops for a lone request. One edge after that, `rg_drv[i]` is high for exactly one cycle and `bus_owner` becomes 2+i (2 is channel 0, 3 is channel 1). `bus_float` then stays 1.
- R3: A grant pulse is always preceded by exactly one cycle in which `bus_float` is 1 and no `rg_drv` bit is high. No grant is driven in the cycle right after its request was sampled.
- R4: While channel i owns the bus, a pulse on `rg_in[i]` returns the bus: after that edge, `bus_owner` is 0 and `bus_float` is 0.
- R5: If both channels pulse in the same cycle, channel 0 is granted first. Channel 1 stays pending with `req_pending` at 1, and is floated one edge after channel 0 returns the bus, then granted.
- R6: A request pulse on the other channel while a coprocessor owns the bus is latched: `req_pending` is 1, no `rg_drv` bit rises, and ownership does not change until the owner returns the bus.
- R7: With `serve_always` at 0, a request arriving while `cpu_run` is 0 is held: `req_pending` stays 1 and `bus_float` stays 0. One edge after `cpu_run` is sampled high, `bus_float` rises and the grant follows as in R2.
- R8: With `serve_always` at 1, pulse-mode requests are granted with the R2 timing while `cpu_run` is 0.
- R9: In level mode (`pulse_mode` 0), `hold_req` is served regardless of `serve_always` and `cpu_run`. One edge after `hold_req` is sampled high, `hold_ack` and `bus_float` are 1 and `bus_owner` is 1. One edge after it is sampled low, all three return to 0.
- R10: In level mode, pulses on `rg_in` are ignored. No request is latched and no `rg_drv` bit rises, so switching to pulse mode afterwards leaves `bus_owner` at 0 and `bus_float` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_mode | input | 1 | 1 selects the pulse request/grant channels, 0 selects the hold/acknowledge levels |
| serve_always | input | 1 | 1 serves pulse requests at any time, 0 serves them only while cpu_run is high |
| cpu_run | input | 1 | High while the processor is running |
| hold_req | input | 1 | Level-mode hold request |
| hold_ack | output | 1 | Level-mode acknowledge, high while the hold device owns the bus |
| rg_in | input | NUM_CH | Sampled level of each channel's shared wire, high during a pulse |
| rg_drv | output | NUM_CH | High while the controller drives the grant pulse on that channel |
| bus_float | output | 1 | Bus outputs released |
| req_pending | output | 1 | At least one latched channel request is not yet being served |
| bus_owner | output | OWN_W | 0 processor, 1 hold device, 2+i channel i |

## Verification
A lost or stuck pending bit shows at the ports within one edge, either as `req_pending` holding a wrong level or as a float that begins for a request nobody made. A wrong sequencer state shows one edge later as a grant pulse with no preceding float cycle or a grant longer than one cycle. A wrong captured channel index shows as the grant pulse landing on the other wire and `bus_owner` naming the wrong channel. The same index fault makes the return pulse on the true owner's wire fail to give the bus back.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FLOAT = 3'd1,
      ST_GRANT = 3'd2,
      ST_OWNED = 3'd3,
      ST_HOLD  = 3'd4
   } rgc_state_e;

   localparam int OWN_PROC = 0;
   localparam int OWN_HOLD = 1;
   localparam int OWN_CH0  = 2;
endpackage

// File: rtl/rgc_pend.sv
module rgc_pend #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [NUM_CH-1:0] rg_in,
   input  logic [NUM_CH-1:0] mask,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] pend
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic pend_q;
      logic set_c;

      always_comb set_c = en & rg_in[i] & ~mask[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (clr[i])
            pend_q <= 1'b0;
         else if (set_c)
            pend_q <= 1'b1;
      end

      assign pend[i] = pend_q;
   end
endmodule

// File: rtl/rgc_pick.sv
module rgc_pick #(
   parameter int NUM_CH = 2,
   parameter int IDX_W  = 1
) (
   input  logic [NUM_CH-1:0] req,
   output logic              any,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rgc_seq.sv
module rgc_seq
   import rgc_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int IDX_W  = 1,
   parameter int OWN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_mode,
   input  logic              allow,
   input  logic              hold_req,
   input  logic [NUM_CH-1:0] rg_in,
   input  logic              pick_any,
   input  logic [IDX_W-1:0]  pick_idx,
   output logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] drv,
   output logic              float_o,
   output logic              ack_o,
   output logic [OWN_W-1:0]  owner
);
   rgc_state_e       st_q, st_d;
   logic [IDX_W-1:0] ch_q, ch_d;
   logic [NUM_CH-1:0] ch_oh;
   logic             ret_c;

   always_comb begin
      ch_oh = '0;
      ch_oh[ch_q] = 1'b1;
   end

   always_comb ret_c = |(rg_in & ch_oh);

   always_comb begin
      st_d = st_q;
      ch_d = ch_q;
      clr  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (!pulse_mode) begin
               if (hold_req) st_d = ST_HOLD;
            end else if (pick_any && allow) begin
               st_d = ST_FLOAT;
               ch_d = pick_idx;
               clr[pick_idx] = 1'b1;
            end
         end
         ST_FLOAT: st_d = ST_GRANT;
         ST_GRANT: st_d = ST_OWNED;
         ST_OWNED: if (ret_c) st_d = ST_IDLE;
         ST_HOLD:  if (!hold_req) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ch_q <= '0;
      end else begin
         st_q <= st_d;
         ch_q <= ch_d;
      end
   end

   always_comb begin
      drv     = (st_q == ST_GRANT) ? ch_oh : '0;
      mask    = (st_q == ST_GRANT || st_q == ST_OWNED) ? ch_oh : '0;
      float_o = (st_q != ST_IDLE);
      ack_o   = (st_q == ST_HOLD);
      if (st_q == ST_HOLD)
         owner = OWN_W'(OWN_HOLD);
      else if (st_q == ST_GRANT || st_q == ST_OWNED)
         owner = OWN_W'(OWN_CH0) + OWN_W'(ch_q);
      else
         owner = OWN_W'(OWN_PROC);
   end
endmodule

// File: rtl/rgc_bus_owner_ctl.sv
module rgc_bus_owner_ctl #(
   parameter int NUM_CH = 2,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int OWN_W = $clog2(NUM_CH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_mode,
   input  logic              serve_always,
   input  logic              cpu_run,
   input  logic              hold_req,
   output logic              hold_ack,
   input  logic [NUM_CH-1:0] rg_in,
   output logic [NUM_CH-1:0] rg_drv,
   output logic              bus_float,
   output logic              req_pending,
   output logic [OWN_W-1:0]  bus_owner
);
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_num_ch
      $error("rgc_bus_owner_ctl: NUM_CH must lie in 1..8");
   end

   logic [NUM_CH-1:0] pend, clr, mask;
   logic              pick_any;
   logic [IDX_W-1:0]  pick_idx;
   logic              allow;

   always_comb allow = serve_always | cpu_run;

   rgc_pend #(.NUM_CH(NUM_CH)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pulse_mode),
      .rg_in (rg_in),
      .mask  (mask),
      .clr   (clr),
      .pend  (pend)
   );

   rgc_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
      .req (pend),
      .any (pick_any),
      .idx (pick_idx)
   );

   rgc_seq #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .OWN_W(OWN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pulse_mode (pulse_mode),
      .allow      (allow),
      .hold_req   (hold_req),
      .rg_in      (rg_in),
      .pick_any   (pick_any),
      .pick_idx   (pick_idx),
      .clr        (clr),
      .mask       (mask),
      .drv        (rg_drv),
      .float_o    (bus_float),
      .ack_o      (hold_ack),
      .owner      (bus_owner)
   );

   always_comb req_pending = |pend;
endmodule

// File: rtl/rgc_chk.sv
module rgc_chk #(
   parameter int NUM_CH = 2,
   parameter int OWN_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pulse_mode,
   input logic              hold_ack,
   input logic [NUM_CH-1:0] rg_drv,
   input logic              bus_float,
   input logic [OWN_W-1:0]  bus_owner
);
   a_r3_float_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (|rg_drv) |-> ($past(bus_float) && $past(rg_drv) == '0));

   a_r2_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (|rg_drv) |=> (rg_drv == '0));

   a_r2_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rg_drv));

   a_r2_owner_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_owner != '0) |-> bus_float);

   a_r9_ack_owner: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (bus_owner == OWN_W'(1)));

   a_r10_no_drive_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode && !$past(pulse_mode)) |-> (rg_drv == '0));
endmodule

bind rgc_bus_owner_ctl rgc_chk #(.NUM_CH(NUM_CH), .OWN_W(OWN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pulse_mode (pulse_mode),
   .hold_ack   (hold_ack),
   .rg_drv     (rg_drv),
   .bus_float  (bus_float),
   .bus_owner  (bus_owner)
);

// File: tb/tb_rgc_bus_owner_ctl.sv
module tb_rgc_bus_owner_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pulse_mode = 1'b1;
   logic       serve_always = 1'b1;
   logic       cpu_run = 1'b0;
   logic       hold_req = 1'b0;
   logic       hold_ack;
   logic [1:0] rg_in = 2'b00;
   logic [1:0] rg_drv;
   logic       bus_float;
   logic       req_pending;
   logic [1:0] bus_owner;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rgc_bus_owner_ctl #(.NUM_CH(2)) dut (
      .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode),
      .serve_always(serve_always), .cpu_run(cpu_run),
      .hold_req(hold_req), .hold_ack(hold_ack), .rg_in(rg_in),
      .rg_drv(rg_drv), .bus_float(bus_float),
      .req_pending(req_pending), .bus_owner(bus_owner)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse(input int ch);
      rg_in[ch] = 1'b1;
      step();
      rg_in[ch] = 1'b0;
   endtask

   // Request on ch, from idle, through to ownership (service allowed)
   task automatic take(input int ch, input string tag);
      pulse(ch);
      check({tag, " pending after request"}, req_pending, 1);
      check({tag, " no float yet"}, bus_float, 0);
      step();
      check({tag, " R3 float cycle"}, bus_float, 1);
      check({tag, " R3 no drive in float cycle"}, rg_drv, 0);
      check({tag, " owner still processor"}, bus_owner, 0);
      step();
      check({tag, " grant pulse"}, rg_drv, 1 << ch);
      check({tag, " owner channel"}, bus_owner, 2 + ch);
      step();
      check({tag, " grant one cycle"}, rg_drv, 0);
      check({tag, " float while owned"}, bus_float, 1);
   endtask

   task automatic give_back(input int ch, input string tag);
      pulse(ch);
      check({tag, " R4 owner back"}, bus_owner, 0);
      check({tag, " R4 float off"}, bus_float, 0);
   endtask

   task automatic t_reset();
      check("R1 owner in reset", bus_owner, 0);
      check("R1 float in reset", bus_float, 0);
      check("R1 drive in reset", rg_drv, 0);
      check("R1 pending in reset", req_pending, 0);
      check("R1 ack in reset", hold_ack, 0);
      rst_n = 1'b1;
      step(); step();
      check("R1 idle after reset", {bus_float, req_pending, hold_ack, bus_owner, rg_drv}, 0);
   endtask

   task automatic t_basic();
      serve_always = 1'b1; cpu_run = 1'b1;
      take(0, "R2 ch0");
      give_back(0, "R4 ch0");
      take(1, "R2 ch1");
      check("R2 ch1 pending cleared", req_pending, 0);
      give_back(1, "R4 ch1");
   endtask

   task automatic t_simul();
      rg_in = 2'b11; step(); rg_in = 2'b00;
      step();
      check("R5 float for ch0", bus_float, 1);
      check("R5 ch1 still pending", req_pending, 1);
      step();
      check("R5 ch0 first", rg_drv, 1);
      step();
      give_back(0, "R5 ch0");
      check("R5 ch1 pending after return", req_pending, 1);
      step();
      check("R5 ch1 float", bus_float, 1);
      step();
      check("R5 ch1 grant", rg_drv, 2);
      check("R5 ch1 owner", bus_owner, 3);
      step();
      give_back(1, "R5 ch1");
   endtask

   task automatic t_held();
      take(0, "R6 owner ch0");
      pulse(1);
      for (int k = 0; k < 3; k++) begin
         check("R6 other held pending", req_pending, 1);
         check("R6 no drive while owned", rg_drv, 0);
         check("R6 owner unchanged", bus_owner, 2);
         step();
      end
      give_back(0, "R6 ch0");
      step();
      check("R6 ch1 float after return", bus_float, 1);
      step();
      check("R6 ch1 grant", rg_drv, 2);
      step();
      give_back(1, "R6 ch1");
   endtask

   task automatic t_gated();
      serve_always = 1'b0; cpu_run = 1'b0;
      pulse(0);
      for (int k = 0; k < 4; k++) begin
         check("R7 held while stopped", bus_float, 0);
         check("R7 pending while stopped", req_pending, 1);
         step();
      end
      cpu_run = 1'b1;
      step();
      check("R7 float once running", bus_float, 1);
      step();
      check("R7 grant once running", rg_drv, 1);
      step();
      give_back(0, "R7 ch0");
      cpu_run = 1'b0;
   endtask

   task automatic t_cont();
      serve_always = 1'b1; cpu_run = 1'b0;
      take(1, "R8 continuous ch1");
      give_back(1, "R8 ch1");
   endtask

   task automatic t_hold();
      pulse_mode = 1'b0; serve_always = 1'b0; cpu_run = 1'b0;
      step();
      hold_req = 1'b1;
      step();
      check("R9 ack", hold_ack, 1);
      check("R9 float", bus_float, 1);
      check("R9 owner hold", bus_owner, 1);
      step();
      check("R9 ack held", hold_ack, 1);
      hold_req = 1'b0;
      step();
      check("R9 ack drop", hold_ack, 0);
      check("R9 float drop", bus_float, 0);
      check("R9 owner back", bus_owner, 0);
   endtask

   task automatic t_level_ignore();
      pulse_mode = 1'b0; serve_always = 1'b1;
      pulse(0);
      pulse(1);
      check("R10 no pending in level mode", req_pending, 0);
      step();
      check("R10 no drive in level mode", rg_drv, 0);
      pulse_mode = 1'b1;
      step(); step(); step();
      check("R10 owner after switch", bus_owner, 0);
      check("R10 float after switch", bus_float, 0);
      check("R10 no drive after switch", rg_drv, 0);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      t_basic();
      t_simul();
      t_held();
      t_gated();
      t_cont();
      t_hold();
      t_level_ignore();
      step();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule